// File: doc/BRIEF.md
# Sub-Word I/O Window Decoder

This block fronts a 128-byte I/O window and presents it to the host as a byte-addressable, little-endian space that accepts byte, halfword and word accesses. Behind it sit three 32-bit register targets: a SCSI core register file, a bank of DMA channel registers and a single bus/control word. The decoder turns every host access into whole-word transactions on a shared target port, so the targets never see byte enables.

A read fetches the addressed word and returns it realigned to bit 0 and masked to the access size. A full, aligned word write goes straight to the target. Any narrower or unaligned write is widened into a read-modify-write. The current word is fetched first, the accessed bytes are merged into it, and the result is committed as one aligned word write. Addresses outside the three regions read as zero and swallow writes.

The controller has four states. `ST_IDLE` accepts requests. `ST_FETCH` reads the word to be merged. `ST_COMMIT` writes the merged or full word. `ST_READ` fetches read data. The transitions are:
- IDLE to COMMIT on an in-window full aligned write.
- IDLE to FETCH on an in-window narrow or unaligned write.
- IDLE to READ on any read.
- IDLE to IDLE on a write into a hole.
- FETCH to COMMIT.
- COMMIT to IDLE.
- READ to IDLE.

Top module: `io_window_decoder`

## Requirements
- R1: After reset `req_ready` is 1, and `rsp_valid`, `tgt_rd_en` and `tgt_wr_en` are 0.
- R2: Word addresses 0x00 to 0x3F select the core target (`tgt_sel` = 0) with `tgt_idx` = address >> 2.
- R3: Word addresses 0x40 to 0x5F select the DMA target (`tgt_sel` = 1) with `tgt_idx` = (address - 0x40) >> 2.
- R4: Addresses 0x70 to 0x73 select the control word (`tgt_sel` = 2, `tgt_idx` = 0).
- R5: Every other address is a hole. A read of a hole returns 0. A write to a hole raises neither `tgt_rd_en` nor `tgt_wr_en`, leaves every target word unchanged and keeps `req_ready` high.
- R6: An in-window write with `req_size` of 2 or 3 (word) and address bits [1:0] = 0 raises `tgt_wr_en` in the cycle after acceptance, with `tgt_wdata` equal to the host data, and performs no target read.
- R7: Any other in-window write reads the current word in the cycle after acceptance and writes the merged word in the following cycle. Byte lanes are numbered from address bit [1:0]. Host byte k goes to lane offset+k, and every lane outside the access keeps its current value. `req_size` 0 means 1 byte and 1 means 2 bytes.
- R8: An access that runs past byte 3 of the addressed word is truncated to the lanes inside that word.
- R9: Read data is the addressed word shifted right by 8 × address[1:0] and masked to 8, 16 or 32 bits by the size. `rsp_valid` pulses for one cycle, two cycles after acceptance.
- R10: `req_ready` is low while the block is fetching, committing or reading, and a request is accepted only while it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Block can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 7 | Byte offset in the window |
| req_size | input | 2 | 0 byte, 1 halfword, 2/3 word |
| req_wdata | input | 32 | Write data, least significant byte first |
| rsp_valid | output | 1 | Read data valid pulse |
| rsp_rdata | output | 32 | Aligned, masked read data |
| tgt_sel | output | 2 | Target select: 0 core, 1 DMA, 2 control, 3 none |
| tgt_idx | output | 5 | Word index in the selected target |
| tgt_rd_en | output | 1 | Target word read strobe |
| tgt_wr_en | output | 1 | Target full-word write strobe |
| tgt_wdata | output | 32 | Target write word |
| tgt_rdata | input | 32 | Target read word, same cycle as `tgt_rd_en` |

## Verification
Random accesses mix every size with every byte offset across the whole window, holes included. This shows whether lane placement, merging and truncation agree with an independent byte-level model. Directed accesses then probe the region edges (0x3C, 0x40, 0x5C, 0x60, 0x70, 0x74, 0x7C), which tell the decode boundaries apart. Word writes at offsets 1 and 3 and halfwords at offset 3 exercise truncation, and separate a true merge from a plain overwrite. Counting target strobes per access distinguishes the direct write path from the read-modify-write path, and shows that hole writes are discarded.

// File: rtl/iowin_pkg.sv
package iowin_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FETCH  = 2'd1,
        ST_COMMIT = 2'd2,
        ST_READ   = 2'd3
    } iowin_state_e;

    typedef enum logic [1:0] {
        TGT_CORE = 2'd0,
        TGT_DMA  = 2'd1,
        TGT_CTRL = 2'd2,
        TGT_NONE = 2'd3
    } iowin_tgt_e;

endpackage

// File: rtl/iowin_region_map.sv
module iowin_region_map #(
    parameter  int ADDR_W   = 7,
    parameter  int OFF_W    = 2,
    parameter  int CORE_END = 64,
    parameter  int DMA_BEG  = 64,
    parameter  int DMA_END  = 96,
    parameter  int CTRL_AT  = 112,
    localparam int IDX_W    = ADDR_W - OFF_W
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [1:0]        sel,
    output logic [IDX_W-1:0]  idx
);
    import iowin_pkg::*;

    int unsigned word_addr;

    // Region decisions are made on the word-aligned address only
    assign word_addr = 32'({addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}});

    always_comb begin
        hit = 1'b0;
        sel = TGT_NONE;
        idx = '0;
        if (word_addr < CORE_END) begin
            hit = 1'b1;
            sel = TGT_CORE;
            idx = IDX_W'(word_addr >> OFF_W);
        end else if (word_addr >= DMA_BEG && word_addr < DMA_END) begin
            hit = 1'b1;
            sel = TGT_DMA;
            idx = IDX_W'((word_addr - DMA_BEG) >> OFF_W);
        end else if (word_addr == CTRL_AT) begin
            hit = 1'b1;
            sel = TGT_CTRL;
        end
    end

endmodule

// File: rtl/iowin_lane_unit.sv
module iowin_lane_unit #(
    parameter  int DATA_W = 32,
    localparam int LANES  = DATA_W / 8,
    localparam int OFF_W  = $clog2(LANES)
) (
    input  logic [OFF_W-1:0]  off,
    input  logic [1:0]        size,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] cur,
    output logic [DATA_W-1:0] bitmask,
    output logic [DATA_W-1:0] merged,
    output logic [DATA_W-1:0] rdalign
);
    logic [LANES-1:0]  size_lanes;
    logic [LANES-1:0]  lanes;
    logic [DATA_W-1:0] size_bits;

    always_comb begin
        case (size)
            2'd0:    size_lanes = LANES'(1);
            2'd1:    size_lanes = LANES'(3);
            default: size_lanes = '1;
        endcase
    end

    // Left shift drops lanes past the word: boundary truncation
    assign lanes = size_lanes << off;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign bitmask[8*g +: 8]   = {8{lanes[g]}};
        assign size_bits[8*g +: 8] = {8{size_lanes[g]}};
    end

    assign merged  = (cur & ~bitmask) | ((wdata << {off, 3'b000}) & bitmask);
    assign rdalign = (cur >> {off, 3'b000}) & size_bits;

endmodule

// File: rtl/io_window_decoder.sv
module io_window_decoder #(
    parameter  int ADDR_W   = 7,
    parameter  int DATA_W   = 32,
    parameter  int CORE_END = 64,
    parameter  int DMA_BEG  = 64,
    parameter  int DMA_END  = 96,
    parameter  int CTRL_AT  = 112,
    localparam int OFF_W    = $clog2(DATA_W / 8),
    localparam int IDX_W    = ADDR_W - OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [1:0]        tgt_sel,
    output logic [IDX_W-1:0]  tgt_idx,
    output logic              tgt_rd_en,
    output logic              tgt_wr_en,
    output logic [DATA_W-1:0] tgt_wdata,
    input  logic [DATA_W-1:0] tgt_rdata
);
    import iowin_pkg::*;

    iowin_state_e      state_q, state_d;
    logic [ADDR_W-1:0] lat_addr;
    logic [1:0]        lat_size;
    logic [DATA_W-1:0] lat_wdata;
    logic [DATA_W-1:0] wbuf_q;
    logic [DATA_W-1:0] rsp_q;
    logic              rsp_valid_q;

    logic [ADDR_W-1:0] map_addr;
    logic              acc_hit;
    logic              acc_full;
    logic [1:0]        map_sel;
    logic [IDX_W-1:0]  map_idx;
    logic [DATA_W-1:0] lane_bits;
    logic [DATA_W-1:0] merged;
    logic [DATA_W-1:0] rdalign;

    // Decode the live request while idle, the held request otherwise
    assign map_addr = (state_q == ST_IDLE) ? req_addr : lat_addr;
    assign acc_full = req_size[1] && (req_addr[OFF_W-1:0] == '0);

    iowin_region_map #(
        .ADDR_W(ADDR_W), .OFF_W(OFF_W), .CORE_END(CORE_END),
        .DMA_BEG(DMA_BEG), .DMA_END(DMA_END), .CTRL_AT(CTRL_AT)
    ) u_map (
        .addr(map_addr),
        .hit (acc_hit),
        .sel (map_sel),
        .idx (map_idx)
    );

    iowin_lane_unit #(.DATA_W(DATA_W)) u_lane (
        .off    (lat_addr[OFF_W-1:0]),
        .size   (lat_size),
        .wdata  (lat_wdata),
        .cur    (tgt_rdata),
        .bitmask(lane_bits),
        .merged (merged),
        .rdalign(rdalign)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    if (!req_write)    state_d = ST_READ;
                    else if (!acc_hit) state_d = ST_IDLE;
                    else if (acc_full) state_d = ST_COMMIT;
                    else               state_d = ST_FETCH;
                end
            end
            ST_FETCH:  state_d = ST_COMMIT;
            ST_COMMIT: state_d = ST_IDLE;
            ST_READ:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_addr    <= '0;
            lat_size    <= '0;
            lat_wdata   <= '0;
            wbuf_q      <= '0;
            rsp_q       <= '0;
            rsp_valid_q <= 1'b0;
        end else begin
            rsp_valid_q <= (state_q == ST_READ);
            if (state_q == ST_IDLE && req_valid) begin
                lat_addr  <= req_addr;
                lat_size  <= req_size;
                lat_wdata <= req_wdata;
                wbuf_q    <= req_wdata;
            end
            if (state_q == ST_FETCH) wbuf_q <= merged;
            if (state_q == ST_READ)  rsp_q  <= acc_hit ? rdalign : '0;
        end
    end

    always_comb begin
        req_ready = (state_q == ST_IDLE);
        tgt_rd_en = (state_q == ST_FETCH || state_q == ST_READ) && acc_hit;
        tgt_wr_en = (state_q == ST_COMMIT);
        tgt_wdata = wbuf_q;
        tgt_sel   = map_sel;
        tgt_idx   = map_idx;
        rsp_valid = rsp_valid_q;
        rsp_rdata = rsp_q;
    end

endmodule

// File: rtl/iowin_checker.sv
module iowin_checker #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              req_write,
    input logic [DATA_W-1:0] req_wdata,
    input logic              rsp_valid,
    input logic [DATA_W-1:0] rsp_rdata,
    input logic              tgt_rd_en,
    input logic              tgt_wr_en,
    input logic [DATA_W-1:0] tgt_wdata,
    input logic [DATA_W-1:0] tgt_rdata,
    input logic              acc_hit,
    input logic              acc_full,
    input logic [DATA_W-1:0] lane_bits
);
    logic accept;
    assign accept = req_valid && req_ready;

    // R6
    full_write_direct_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept && req_write && acc_hit && acc_full
        |=> tgt_wr_en && !tgt_rd_en && tgt_wdata == $past(req_wdata));

    // R7
    narrow_fetch_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept && req_write && acc_hit && !acc_full
        |=> tgt_rd_en && !tgt_wr_en ##1 tgt_wr_en);

    // R7
    merge_keeps_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_wr_en && $past(tgt_rd_en)
        |-> ((tgt_wdata ^ $past(tgt_rdata)) & ~lane_bits) == '0);

    // R5
    hole_write_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept && req_write && !acc_hit
        |=> !tgt_wr_en && !tgt_rd_en && req_ready);

    // R5
    hole_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept && !req_write && !acc_hit
        |=> ##1 rsp_valid && rsp_rdata == '0);

    // R9
    read_resp_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept && !req_write |=> !rsp_valid ##1 rsp_valid);

    // R10
    busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_rd_en || tgt_wr_en) |-> !req_ready);

endmodule

bind io_window_decoder iowin_checker #(.DATA_W(DATA_W)) u_iowin_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_ready(req_ready),
    .req_write(req_write),
    .req_wdata(req_wdata),
    .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata),
    .tgt_rd_en(tgt_rd_en),
    .tgt_wr_en(tgt_wr_en),
    .tgt_wdata(tgt_wdata),
    .tgt_rdata(tgt_rdata),
    .acc_hit  (acc_hit),
    .acc_full (acc_full),
    .lane_bits(lane_bits)
);

// File: tb/test_io_window_decoder.sv
module test_io_window_decoder;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [6:0]  req_addr = '0;
    logic [1:0]  req_size = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic [1:0]  tgt_sel;
    logic [4:0]  tgt_idx;
    logic        tgt_rd_en;
    logic        tgt_wr_en;
    logic [31:0] tgt_wdata;
    logic [31:0] tgt_rdata;

    int n_chk = 0;
    int n_fail = 0;
    int rd_cnt = 0;
    int wr_cnt = 0;
    logic [1:0] last_sel;
    logic [4:0] last_idx;

    logic [31:0] core_m [16];
    logic [31:0] dma_m  [8];
    logic [31:0] ctrl_m;
    logic [31:0] core_r [16];
    logic [31:0] dma_r  [8];
    logic [31:0] ctrl_r;

    always #(CLK_PERIOD/2) clk = ~clk;

    io_window_decoder i_io_window_decoder (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .tgt_sel(tgt_sel), .tgt_idx(tgt_idx), .tgt_rd_en(tgt_rd_en),
        .tgt_wr_en(tgt_wr_en), .tgt_wdata(tgt_wdata), .tgt_rdata(tgt_rdata)
    );

    // Target register model
    always_comb begin
        case (tgt_sel)
            2'd0:    tgt_rdata = core_m[tgt_idx[3:0]];
            2'd1:    tgt_rdata = dma_m[tgt_idx[2:0]];
            2'd2:    tgt_rdata = ctrl_m;
            default: tgt_rdata = 32'hDEAD_BEEF;
        endcase
    end

    always @(posedge clk) begin
        if (tgt_rd_en) rd_cnt <= rd_cnt + 1;
        if (tgt_wr_en) begin
            wr_cnt   <= wr_cnt + 1;
            last_sel <= tgt_sel;
            last_idx <= tgt_idx;
            case (tgt_sel)
                2'd0:    core_m[tgt_idx[3:0]] <= tgt_wdata;
                2'd1:    dma_m[tgt_idx[2:0]]  <= tgt_wdata;
                2'd2:    ctrl_m               <= tgt_wdata;
                default: ;
            endcase
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int region(input logic [6:0] a);
        int w = int'({a[6:2], 2'b00});
        if (w < 64) return 0;
        if (w < 96) return 1;
        if (w == 112) return 2;
        return 3;
    endfunction

    function automatic int ridx(input logic [6:0] a);
        int w = int'({a[6:2], 2'b00});
        return (region(a) == 1) ? (w - 64) / 4 : (region(a) == 0 ? w / 4 : 0);
    endfunction

    function automatic int nbytes(input logic [1:0] sz);
        return (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    endfunction

    function automatic logic [31:0] ref_get(input logic [6:0] a);
        case (region(a))
            0:       return core_r[ridx(a)];
            1:       return dma_r[ridx(a)];
            2:       return ctrl_r;
            default: return 32'h0;
        endcase
    endfunction

    task automatic ref_put(input logic [6:0] a, input logic [31:0] v);
        case (region(a))
            0:       core_r[ridx(a)] = v;
            1:       dma_r[ridx(a)]  = v;
            2:       ctrl_r          = v;
            default: ;
        endcase
    endtask

    function automatic logic [31:0] exp_read(input logic [6:0] a, input logic [1:0] sz);
        logic [31:0] w = ref_get(a) >> (8 * int'(a[1:0]));
        return (nbytes(sz) == 4) ? w : (w & ((32'h1 << (8 * nbytes(sz))) - 1));
    endfunction

    function automatic logic [31:0] exp_merge(input logic [31:0] cur, input logic [6:0] a,
                                              input logic [1:0] sz, input logic [31:0] d);
        logic [31:0] r = cur;
        int off = int'(a[1:0]);
        for (int b = 0; b < 4; b++)
            if (b >= off && b < off + nbytes(sz)) r[8*b +: 8] = d[8*(b-off) +: 8];
        return r;
    endfunction

    function automatic bit models_match();
        for (int i = 0; i < 16; i++) if (core_m[i] !== core_r[i]) return 1'b0;
        for (int i = 0; i < 8; i++)  if (dma_m[i] !== dma_r[i])   return 1'b0;
        return ctrl_m === ctrl_r;
    endfunction

    task automatic do_op(input bit wr, input logic [6:0] a, input logic [1:0] sz, input logic [31:0] d);
        int rd0, wr0, reg_n;
        bit full, trunc;
        string tag;
        reg_n = region(a);
        full  = (nbytes(sz) == 4) && (a[1:0] == 2'b00);
        trunc = (int'(a[1:0]) + nbytes(sz)) > 4;
        if (reg_n == 3)   tag = "R5";
        else if (!wr)     tag = "R9";
        else if (full)    tag = "R6";
        else if (trunc)   tag = "R8";
        else              tag = "R7";
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        rd0 = rd_cnt; wr0 = wr_cnt;
        req_valid = 1'b1; req_write = wr; req_addr = a; req_size = sz; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        if (!wr || reg_n != 3) chk("R10 busy", 32'(req_ready), 32'd0);
        while (!req_ready) @(negedge clk);
        if (!wr) begin
            chk("R9 rsp_valid", 32'(rsp_valid), 32'd1);
            chk(tag, rsp_rdata, exp_read(a, sz));
            chk({tag, " rd strobes"}, 32'(rd_cnt - rd0), (reg_n == 3) ? 32'd0 : 32'd1);
        end else begin
            if (reg_n != 3) ref_put(a, exp_merge(ref_get(a), a, sz, d));
            chk({tag, " wr strobes"}, 32'(wr_cnt - wr0), (reg_n == 3) ? 32'd0 : 32'd1);
            chk({tag, " rd strobes"}, 32'(rd_cnt - rd0), (reg_n == 3 || full) ? 32'd0 : 32'd1);
            chk({tag, " target words"}, 32'(models_match()), 32'd1);
            if (reg_n != 3) begin
                if (reg_n == 0)      tag = "R2";
                else if (reg_n == 1) tag = "R3";
                else                 tag = "R4";
                chk({tag, " sel"}, 32'(last_sel), 32'(reg_n));
                chk({tag, " idx"}, 32'(last_idx), 32'(ridx(a)));
            end
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 16; i++) begin
            core_m[i] = 32'h1000_0000 + i * 32'h0101_0103;
            core_r[i] = core_m[i];
        end
        for (int i = 0; i < 8; i++) begin
            dma_m[i] = 32'h8000_0000 ^ (i * 32'h0303_0307);
            dma_r[i] = dma_m[i];
        end
        ctrl_m = 32'hC0DE_F00D;
        ctrl_r = ctrl_m;
        void'($urandom(32'd4711));
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        chk("R1 ready", 32'(req_ready), 32'd1);
        chk("R1 rsp_valid", 32'(rsp_valid), 32'd0);
        chk("R1 rd_en", 32'(tgt_rd_en), 32'd0);
        chk("R1 wr_en", 32'(tgt_wr_en), 32'd0);
        rst_n = 1'b1;

        // Directed corners: region edges, holes, truncation
        do_op(1, 7'h3C, 2'd2, 32'hAABB_CCDD);  // R2 last core word
        do_op(1, 7'h40, 2'd0, 32'h0000_0077);  // R3 first DMA byte
        do_op(1, 7'h5E, 2'd1, 32'h0000_1234);  // R3 upper half
        do_op(1, 7'h60, 2'd2, 32'hFFFF_FFFF);  // R5 hole write
        do_op(0, 7'h60, 2'd2, 32'h0);          // R5 hole read
        do_op(0, 7'h7C, 2'd0, 32'h0);          // R5 hole read
        do_op(1, 7'h74, 2'd1, 32'h5555_5555);  // R5 hole past control
        do_op(1, 7'h70, 2'd2, 32'h1122_3344);  // R4 control word
        do_op(1, 7'h71, 2'd1, 32'h0000_BEEF);  // R4 R7 mid-word half
        do_op(1, 7'h43, 2'd2, 32'h99AA_BBCC);  // R8 word at offset 3
        do_op(1, 7'h07, 2'd1, 32'h0000_6655);  // R8 half at offset 3
        do_op(1, 7'h09, 2'd3, 32'hA1B2_C3D4);  // R8 size 3 at offset 1
        do_op(0, 7'h41, 2'd0, 32'h0);          // R9 byte read
        do_op(0, 7'h72, 2'd1, 32'h0);          // R9 half read
        do_op(0, 7'h73, 2'd2, 32'h0);          // R9 R8 truncated read
        do_op(0, 7'h3C, 2'd2, 32'h0);          // R9 word read

        for (int n = 0; n < 400; n++) begin
            logic [6:0] a = 7'($urandom % 128);
            logic [1:0] s = 2'($urandom % 4);
            bit w = 1'($urandom % 2);
            do_op(w, a, s, $urandom);
        end
        finish_run();
    end

endmodule